// File: doc/BRIEF.md
# Zero-Operand Stack Arithmetic Unit

This is a purely combinational 16-bit arithmetic and logic unit for a stack machine whose instructions carry no operands. The surrounding datapath presents the two uppermost stack entries. The entry just below the top is the left operand, and the top entry is the right operand. A 5-bit function code selects the operation. The single 16-bit result is written back by the stack logic as the new top entry.

All values are 16-bit two's complement integers. Binary operations always compute `left op right`, so the operand order comes from stack position alone. Unary operations look only at the top entry. Every comparison and logical operation yields exactly one or zero, so its result can be used directly by a branch-if-zero instruction or by further arithmetic.

Top module: `stk_alu`

## Requirements
- R1: Code 0x00 returns the low 16 bits of left plus right.
- R2: Code 0x01 returns the low 16 bits of left minus right.
- R3: Code 0x02 returns the low 16 bits of the product of left and right.
- R4: Code 0x03 shifts left to the left by right positions. Right is read as an unsigned amount, and an amount of 16 or more gives 0x0000.
- R5: Code 0x04 shifts left to the right by right positions and fills with its sign bit. An unsigned amount of 16 or more gives 0xFFFF for a negative left and 0x0000 otherwise.
- R6: Code 0x05 is bitwise AND, 0x06 is bitwise OR, 0x07 is bitwise XOR, and 0x11 is the bitwise complement of right.
- R7: Code 0x08 is logical AND, 0x09 is logical OR, and 0x12 is logical NOT of right. Any nonzero operand counts as true, and the result is 0x0001 for true and 0x0000 for false.
- R8: Codes 0x0A (equal), 0x0B (not equal), 0x0C (greater or equal), 0x0D (less or equal), 0x0E (greater than) and 0x0F (less than) compare left against right as signed values. The result is 0x0001 for true and 0x0000 for false.
- R9: Code 0x10 returns the two's complement negation of right, and 0x8000 negates to itself.
- R10: Codes 0x13 through 0x1F return right unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn   | input     | 5     | Function code |
| nxt  | input     | 16    | Left operand (entry below the top) |
| tos  | input     | 16    | Right operand (top entry) |
| res  | output    | 16    | Result that replaces the top entry |

## Verification
Embedded immediate assertions are evaluated on every input change. They check algebraic invariants: subtraction and negation undo against the top operand, the complement XORs to all ones, every comparison and logical result is zero or one, and undefined codes pass the top through. Exact values come only from the bench's sweeps. These include signed ordering around 0x7FFF/0x8000, product truncation, sign fill of the arithmetic right shift, and shift amounts at and beyond 16 (including negative top values read as huge amounts). The bench covers all 32 codes over a grid of boundary operands and over random pairs.

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16,
  parameter int FW = 5
) (
  input  logic [FW-1:0] fn,
  input  logic [W-1:0]  nxt,
  input  logic [W-1:0]  tos,
  output logic [W-1:0]  res
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic signed [W-1:0] sn, st;
  logic [2*W-1:0] prod;
  logic lt, eq, nz_n, nz_t;

  assign sn   = nxt;
  assign st   = tos;
  assign prod = nxt * tos;
  assign lt   = sn < st;
  assign eq   = nxt == tos;
  assign nz_n = |nxt;
  assign nz_t = |tos;

  always_comb begin
    case (fn)
      5'h00: res = nxt + tos;
      5'h01: res = nxt - tos;
      5'h02: res = prod[W-1:0];
      5'h03: res = nxt << tos;
      5'h04: res = W'(sn >>> tos);
      5'h05: res = nxt & tos;
      5'h06: res = nxt | tos;
      5'h07: res = nxt ^ tos;
      5'h08: res = (nz_n && nz_t) ? ONE : ZERO;
      5'h09: res = (nz_n || nz_t) ? ONE : ZERO;
      5'h0A: res = eq ? ONE : ZERO;
      5'h0B: res = eq ? ZERO : ONE;
      5'h0C: res = lt ? ZERO : ONE;
      5'h0D: res = (lt || eq) ? ONE : ZERO;
      5'h0E: res = (lt || eq) ? ZERO : ONE;
      5'h0F: res = lt ? ONE : ZERO;
      5'h10: res = ZERO - tos;
      5'h11: res = ~tos;
      5'h12: res = nz_t ? ZERO : ONE;
      default: res = tos;
    endcase
  end

  always_comb begin
    if (!$isunknown({fn, nxt, tos})) begin
      if (fn == 5'h01)
        a_r2_sub_undo: assert (W'(res + tos) == nxt) else $error("R2 sub invariant");
      if (fn == 5'h10)
        a_r9_neg_sum: assert (W'(res + tos) == ZERO) else $error("R9 neg invariant");
      if (fn == 5'h11)
        a_r6_cpl_xor: assert ((res ^ tos) == '1) else $error("R6 complement invariant");
      if ((fn >= 5'h08 && fn <= 5'h0F) || fn == 5'h12)
        a_r8_bool_res: assert (res[W-1:1] == '0) else $error("R7/R8 boolean result");
      if (fn >= 5'h13)
        a_r10_pass_top: assert (res == tos) else $error("R10 passthrough");
    end
  end
endmodule

// File: tb/stk_alu_tb_top.sv
module stk_alu_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [4:0]  fn;
  logic [15:0] nxt, tos, res;
  int checks = 0, failures = 0;
  bit done = 0;

  stk_alu dut_i (.fn(fn), .nxt(nxt), .tos(tos), .res(res));

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'h00: return "R1";
      5'h01: return "R2";
      5'h02: return "R3";
      5'h03: return "R4";
      5'h04: return "R5";
      5'h05, 5'h06, 5'h07, 5'h11: return "R6";
      5'h08, 5'h09, 5'h12: return "R7";
      5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F: return "R8";
      5'h10: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] model(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b);
    int sa, sb, amt, v;
    sa = $signed(a);
    sb = $signed(b);
    amt = int'(b);
    case (c)
      5'h00: return 16'(sa + sb);
      5'h01: return 16'(sa - sb);
      5'h02: return 16'(sa * sb);
      5'h03: begin
        if (amt >= 16) return 16'h0000;
        return 16'(int'(a) * (1 << amt));
      end
      5'h04: begin
        if (amt >= 16) return (sa < 0) ? 16'hFFFF : 16'h0000;
        v = sa;
        for (int k = 0; k < amt; k++) v = (v - (v & 1)) / 2;
        return 16'(v);
      end
      5'h05: return a & b;
      5'h06: return a | b;
      5'h07: return a ^ b;
      5'h08: return 16'((a != 0) && (b != 0));
      5'h09: return 16'((a != 0) || (b != 0));
      5'h0A: return 16'(sa == sb);
      5'h0B: return 16'(sa != sb);
      5'h0C: return 16'(sa >= sb);
      5'h0D: return 16'(sa <= sb);
      5'h0E: return 16'(sa > sb);
      5'h0F: return 16'(sa < sb);
      5'h10: return 16'(-sb);
      5'h11: return 16'hFFFF - b;
      5'h12: return 16'(b == 0);
      default: return b;
    endcase
  endfunction

  task automatic apply(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp;
    @(negedge clk);
    fn = c; nxt = a; tos = b;
    #2;
    exp = model(c, a, b);
    checks++;
    if (res !== exp) begin
      failures++;
      $display("FAIL %s code=%02h next=%04h top=%04h got=%04h exp=%04h",
               req_of(c), c, a, b, res, exp);
    end
  endtask

  logic [15:0] grid [11] = '{16'h0000, 16'h0001, 16'h0002, 16'h000F, 16'h0010,
                             16'h0011, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hF00F};

  initial begin
    fn = 0; nxt = 0; tos = 0;
    apply(5'h00, 16'h0000, 16'h0000);               // R1 idle inputs give zero
    apply(5'h00, 16'h7FFF, 16'h0001);               // R1 wrap to 0x8000
    apply(5'h02, 16'h0100, 16'h0100);               // R3 truncated product
    apply(5'h04, 16'h8000, 16'h000F);               // R5 sign fill
    apply(5'h03, 16'h0001, 16'hFFFF);               // R4 negative top is huge amount
    apply(5'h10, 16'h0000, 16'h8000);               // R9 most negative
    apply(5'h0F, 16'h8000, 16'h7FFF);               // R8 signed order
    apply(5'h12, 16'h0000, 16'h0000);               // R7 not of zero
    apply(5'h1F, 16'hABCD, 16'h5A5A);               // R10 top passes
    for (int c = 0; c < 32; c++) begin
      for (int i = 0; i < 11; i++)
        for (int j = 0; j < 11; j++)
          apply(5'(c), grid[i], grid[j]);
      for (int r = 0; r < 40; r++)
        apply(5'(c), 16'($urandom), 16'($urandom));
      for (int s = 0; s < 20; s++)
        apply(5'(c), 16'($urandom), 16'(s));      // R4 R5 amounts 0..19
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule